// File: doc/BRIEF.md
# Per-Lane Priority Branch Selector

This block evaluates an if/elif/else chain separately in every section column of a datapath whose SIMD lane layout is chosen at run time. The word is split into `NSEC` sections of `SEC_W` bits. A mask of `NSEC-1` split bits decides which neighbouring sections are fused into a wider lane. Each of `NBR` branches supplies one condition bit per section and one candidate data word. In every lane the lowest-numbered branch whose condition is true supplies that lane's sections of the result. When no branch is true, the lane takes its sections from the fallback word, or from zero when the fallback is disabled by parameter. Because each lane makes its own choice, different lanes can follow different branches in the same cycle.

When sections are fused into one lane, the lane must act as a single wider value. For that reason only the condition bits of the lane's lowest section are examined, and the whole lane follows that one decision. The block has no clock and no state. It sits between the logic that produces the condition vectors and the destination register of the datapath. `NBR` may be set from 2 to 4.

Top module: `simd_prio_sel`

## Requirements
- R1: With every split bit set, each section column picks its branch on its own. Bit s of branch b's condition is `cond_flat[b*NSEC+s]`. Section s of branch b's data is `data_flat[(b*NSEC+s)*SEC_W +: SEC_W]`. Section s of `y` is `y[s*SEC_W +: SEC_W]`.
- R2: Within a lane, the lowest-numbered branch whose condition bit is 1 wins. Higher-numbered branches whose bits are also 1 have no effect on the output.
- R3: With `USE_DFLT`=1, a lane in which no condition bit is 1 takes its sections of `y` from the same sections of `dflt`.
- R4: With `USE_DFLT`=0, a lane in which no condition bit is 1 outputs zero in its sections.
- R5: `part_mask[k]`=1 splits sections k and k+1 into separate lanes, and 0 fuses them. A fused lane is decided only by the condition bits of its lowest section. The condition bits of its other sections do not affect `y`.
- R6: All sections of one lane take their data from the same source, either one branch or the fallback.
- R7: The output is a purely combinational function of the inputs. All-zero inputs give an all-zero `y`.
- R8: For all 2^(NSEC-1) mask values and arbitrary conditions, `y` equals a model that selects by priority separately in each lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| part_mask | input | NSEC-1 | Split bits; bit k=1 separates sections k and k+1 |
| cond_flat | input | NBR*NSEC | Condition bits, branch-major, one bit per section |
| data_flat | input | NBR*NSEC*SEC_W | Candidate data words, one per branch |
| dflt | input | NSEC*SEC_W | Fallback word used by lanes with no true condition |
| y | output | NSEC*SEC_W | Selected result |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `y`. The driver task changes the inputs one nanosecond after a rising edge and queues the expected word. The monitor pops that entry at the following falling edge, after the combinational paths have settled and before the next stimulus arrives. The queue therefore holds at most one entry, and each comparison belongs to exactly one input pattern. A second instance built without the fallback receives the same inputs, so the zero-fill result is checked against every pattern as well.

// File: rtl/simd_prio_pkg.sv
package simd_prio_pkg;
  localparam int unsigned MAXBR = 4;

  // lowest set bit as one-hot; zero when nothing is set
  function automatic logic [MAXBR-1:0] first_hit(input logic [MAXBR-1:0] v);
    logic [MAXBR-1:0] g;
    logic taken;
    g = '0;
    taken = 1'b0;
    for (int b = 0; b < MAXBR; b++) begin
      g[b] = v[b] & ~taken;
      taken = taken | v[b];
    end
    return g;
  endfunction

  // flat bit offset of section s of branch b
  function automatic int unsigned sec_base(input int unsigned b, input int unsigned s,
                                           input int unsigned nsec, input int unsigned w);
    return (b * nsec + s) * w;
  endfunction
endpackage

// File: rtl/lane_head_map.sv
module lane_head_map #(
  parameter int unsigned NSEC = 4,
  localparam int unsigned HW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic [NSEC-2:0]    part_mask,
  output logic [NSEC*HW-1:0] head_flat
);
  logic [HW-1:0] cur;

  always_comb begin
    cur = '0;
    head_flat = '0;
    head_flat[0 +: HW] = '0;
    for (int s = 1; s < NSEC; s++) begin
      if (part_mask[s-1]) cur = HW'(s);
      head_flat[s*HW +: HW] = cur;
    end
  end
endmodule

// File: rtl/col_arbiter.sv
module col_arbiter
  import simd_prio_pkg::*;
#(
  parameter int unsigned NBR = 3
) (
  input  logic [NBR-1:0] req,
  output logic [NBR-1:0] grant,
  output logic           none
);
  logic [MAXBR-1:0] req_pad;
  logic [MAXBR-1:0] hit;

  always_comb begin
    req_pad = '0;
    req_pad[NBR-1:0] = req;
    hit = first_hit(req_pad);
    grant = hit[NBR-1:0];
    none = ~|req;
  end
endmodule

// File: rtl/sec_select.sv
module sec_select #(
  parameter int unsigned NBR      = 3,
  parameter int unsigned SEC_W    = 8,
  parameter bit          USE_DFLT = 1'b1
) (
  input  logic [NBR-1:0]       grant,
  input  logic                 none,
  input  logic [NBR*SEC_W-1:0] cand_flat,
  input  logic [SEC_W-1:0]     dflt_sec,
  output logic [SEC_W-1:0]     y_sec
);
  logic [SEC_W-1:0] fallback;

  generate
    if (USE_DFLT) begin : g_dflt
      assign fallback = dflt_sec;
    end else begin : g_zero
      logic unused_dflt;
      assign unused_dflt = ^dflt_sec;
      assign fallback = '0;
    end
  endgenerate

  // AND-OR mux: grant is one-hot or empty
  always_comb begin
    y_sec = none ? fallback : '0;
    for (int b = 0; b < NBR; b++)
      if (grant[b]) y_sec = y_sec | cand_flat[b*SEC_W +: SEC_W];
  end
endmodule

// File: rtl/simd_prio_sel.sv
module simd_prio_sel
  import simd_prio_pkg::*;
#(
  parameter int unsigned NSEC     = 4,
  parameter int unsigned SEC_W    = 8,
  parameter int unsigned NBR      = 3,
  parameter bit          USE_DFLT = 1'b1,
  localparam int unsigned W  = NSEC * SEC_W,
  localparam int unsigned HW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic [NSEC-2:0]   part_mask,
  input  logic [NBR*NSEC-1:0] cond_flat,
  input  logic [NBR*W-1:0]  data_flat,
  input  logic [W-1:0]      dflt,
  output logic [W-1:0]      y
);
  // observable internal events for the checker
  logic [NSEC*HW-1:0]  head_flat;
  logic [NSEC*NBR-1:0] grant_flat;
  logic [NSEC-1:0]     none_vec;

  lane_head_map #(.NSEC(NSEC)) u_heads (
    .part_mask(part_mask),
    .head_flat(head_flat)
  );

  generate
    for (genvar s = 0; s < NSEC; s++) begin : g_col
      logic [NBR-1:0]       req;
      logic [NBR*SEC_W-1:0] cand;
      logic [HW-1:0]        hd;

      assign hd = head_flat[s*HW +: HW];

      always_comb begin
        for (int b = 0; b < NBR; b++)
          req[b] = cond_flat[b*NSEC + int'(hd)];
      end

      for (genvar b = 0; b < NBR; b++) begin : g_cand
        assign cand[b*SEC_W +: SEC_W] =
          data_flat[sec_base(b, s, NSEC, SEC_W) +: SEC_W];
      end

      col_arbiter #(.NBR(NBR)) u_arb (
        .req  (req),
        .grant(grant_flat[s*NBR +: NBR]),
        .none (none_vec[s])
      );

      sec_select #(.NBR(NBR), .SEC_W(SEC_W), .USE_DFLT(USE_DFLT)) u_sel (
        .grant    (grant_flat[s*NBR +: NBR]),
        .none     (none_vec[s]),
        .cand_flat(cand),
        .dflt_sec (dflt[s*SEC_W +: SEC_W]),
        .y_sec    (y[s*SEC_W +: SEC_W])
      );
    end
  endgenerate
endmodule

// File: rtl/simd_prio_sel_chk.sv
module simd_prio_sel_chk #(
  parameter int unsigned NSEC     = 4,
  parameter int unsigned SEC_W    = 8,
  parameter int unsigned NBR      = 3,
  parameter bit          USE_DFLT = 1'b1,
  parameter int unsigned HW       = 2
) (
  input logic [NSEC-2:0]       part_mask,
  input logic [NBR*NSEC-1:0]   cond_flat,
  input logic [NBR*NSEC*SEC_W-1:0] data_flat,
  input logic [NSEC*SEC_W-1:0] dflt,
  input logic [NSEC*SEC_W-1:0] y,
  input logic [NSEC*HW-1:0]    head_flat,
  input logic [NSEC*NBR-1:0]   grant_flat,
  input logic [NSEC-1:0]       none_vec
);
  always_comb begin
    for (int s = 0; s < NSEC; s++) begin
      // R2
      grant_onehot_chk: assert ($onehot0(grant_flat[s*NBR +: NBR]))
        else $error("grant not one-hot in column %0d", s);
      if (s > 0 && !part_mask[s-1]) begin
        // R6
        lane_same_chk: assert (grant_flat[s*NBR +: NBR] == grant_flat[(s-1)*NBR +: NBR]
                               && none_vec[s] == none_vec[s-1])
          else $error("fused column %0d diverges from its neighbour", s);
      end
      for (int b = 0; b < NBR; b++) begin
        if (grant_flat[s*NBR + b]) begin
          // R1
          grant_data_chk: assert (y[s*SEC_W +: SEC_W] ==
                                  data_flat[(b*NSEC + s)*SEC_W +: SEC_W])
            else $error("column %0d output does not match branch %0d", s, b);
          // R5
          head_cond_chk: assert (cond_flat[b*NSEC + int'(head_flat[s*HW +: HW])])
            else $error("column %0d granted without lane-head condition", s);
          for (int e = 0; e < b; e++) begin
            // R2
            no_earlier_chk: assert (!cond_flat[e*NSEC + int'(head_flat[s*HW +: HW])])
              else $error("column %0d skipped earlier branch %0d", s, e);
          end
        end
      end
      if (none_vec[s]) begin
        // R3
        fallback_chk: assert (y[s*SEC_W +: SEC_W] ==
                              (USE_DFLT ? dflt[s*SEC_W +: SEC_W] : '0))
          else $error("column %0d fallback value wrong", s);
      end
    end
  end
endmodule

bind simd_prio_sel simd_prio_sel_chk #(
  .NSEC(NSEC), .SEC_W(SEC_W), .NBR(NBR), .USE_DFLT(USE_DFLT), .HW(HW)
) u_chk (
  .part_mask (part_mask),
  .cond_flat (cond_flat),
  .data_flat (data_flat),
  .dflt      (dflt),
  .y         (y),
  .head_flat (head_flat),
  .grant_flat(grant_flat),
  .none_vec  (none_vec)
);

// File: tb/simd_prio_sel_test.sv
module simd_prio_sel_test;
  localparam int NSEC = 4;
  localparam int SEC_W = 8;
  localparam int NBR = 3;
  localparam int W = NSEC * SEC_W;

  typedef struct {
    logic [W-1:0] exp_d;
    logic [W-1:0] exp_z;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NSEC-2:0]     part_mask = '0;
  logic [NBR*NSEC-1:0] cond_flat = '0;
  logic [NBR*W-1:0]    data_flat = '0;
  logic [W-1:0]        dflt = '0;
  logic [W-1:0]        y_d, y_z;

  int checks = 0;
  int errors = 0;
  item_t sb[$];
  bit done = 1'b0;

  simd_prio_sel #(.NSEC(NSEC), .SEC_W(SEC_W), .NBR(NBR), .USE_DFLT(1'b1)) uut (
    .part_mask(part_mask), .cond_flat(cond_flat), .data_flat(data_flat),
    .dflt(dflt), .y(y_d)
  );

  simd_prio_sel #(.NSEC(NSEC), .SEC_W(SEC_W), .NBR(NBR), .USE_DFLT(1'b0)) uut_nz (
    .part_mask(part_mask), .cond_flat(cond_flat), .data_flat(data_flat),
    .dflt(dflt), .y(y_z)
  );

  // lane-by-lane reference: walk down to the lane start, then scan branches
  function automatic logic [W-1:0] ref_model(input logic [NSEC-2:0] m,
      input logic [NBR*NSEC-1:0] c, input logic [NBR*W-1:0] d,
      input logic [W-1:0] f, input bit use_f);
    logic [W-1:0] r;
    r = '0;
    for (int s = 0; s < NSEC; s++) begin
      int h;
      int pick;
      h = s;
      while (h > 0 && !m[h-1]) h--;
      pick = -1;
      for (int b = NBR - 1; b >= 0; b--)
        if (c[b*NSEC + h]) pick = b;
      if (pick >= 0) r[s*SEC_W +: SEC_W] = d[(pick*NSEC + s)*SEC_W +: SEC_W];
      else if (use_f) r[s*SEC_W +: SEC_W] = f[s*SEC_W +: SEC_W];
    end
    return r;
  endfunction

  task automatic apply(input logic [NSEC-2:0] m, input logic [NBR*NSEC-1:0] c,
                       input logic [NBR*W-1:0] d, input logic [W-1:0] f,
                       input string tag);
    item_t it;
    @(posedge clk);
    #1;
    part_mask = m;
    cond_flat = c;
    data_flat = d;
    dflt = f;
    it.exp_d = ref_model(m, c, d, f, 1'b1);
    it.exp_z = ref_model(m, c, d, f, 1'b0);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // result is combinational: due in the same cycle, sampled at falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (y_d !== it.exp_d) begin
        errors++;
        $display("FAIL %s: y=%h expected %h", it.tag, y_d, it.exp_d);
      end
      checks++;
      if (y_z !== it.exp_z) begin
        errors++;
        $display("FAIL R4 (%s, no fallback): y=%h expected %h", it.tag, y_z, it.exp_z);
      end
    end
  end

  function automatic logic [NBR*W-1:0] patt_data();
    logic [NBR*W-1:0] d;
    for (int b = 0; b < NBR; b++)
      for (int s = 0; s < NSEC; s++)
        d[(b*NSEC + s)*SEC_W +: SEC_W] = 8'(((b + 1) << 4) | (s + 1));
    return d;
  endfunction

  function automatic logic [NBR*NSEC-1:0] cb(input int b, input int s);
    logic [NBR*NSEC-1:0] c;
    c = '0;
    c[b*NSEC + s] = 1'b1;
    return c;
  endfunction

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NBR*W-1:0] pd;
    pd = patt_data();
    repeat (3) @(posedge clk);
    // R7: idle inputs give a zero word
    apply('0, '0, '0, '0, "R7 idle");
    rst_n = 1'b1;
    // R1: fully split, each column a different branch, column 3 none
    apply(3'b111, cb(0, 0) | cb(1, 1) | cb(2, 2), pd, 32'hD3D2D1D0, "R1 split");
    apply(3'b111, cb(2, 0) | cb(0, 3) | cb(1, 1), pd, 32'hA5A5A5A5, "R1 split alt");
    // R2: every condition set, branch 0 wins; then 1 and 2 set, 1 wins
    apply(3'b111, '1, pd, 32'hFFFFFFFF, "R2 all set");
    apply(3'b111, {NBR*NSEC{1'b1}} & ~{{(NBR-1)*NSEC{1'b0}}, {NSEC{1'b1}}}, pd,
          32'h0, "R2 later pair");
    // R3: nothing set, fallback everywhere
    apply(3'b111, '0, pd, 32'hCAFEF00D, "R3 fallback");
    apply(3'b000, '0, pd, 32'h12345678, "R3 fallback fused");
    // R5: fused 32-bit lane decided by section 0 only
    apply(3'b000, cb(1, 0), pd, 32'hEEEEEEEE, "R5 head decides");
    apply(3'b000, cb(0, 1) | cb(0, 2) | cb(0, 3) | cb(2, 0), pd, 32'h0, "R5 others ignored");
    apply(3'b000, cb(0, 3), pd, 32'hBEEFBEEF, "R5 upper bit ignored");
    // R6: lanes {0},{1,2},{3}; condition only in section 2 is ignored
    apply(3'b101, cb(0, 2) | cb(1, 3), pd, 32'h99887766, "R6 mid lane");
    apply(3'b101, cb(2, 1) | cb(0, 0), pd, 32'h0, "R6 mid lane head");
    apply(3'b010, cb(1, 0) | cb(2, 2) | cb(0, 1), pd, 32'h55555555, "R6 two halves");
    // R8: every mask with random conditions and data
    for (int m = 0; m < (1 << (NSEC - 1)); m++) begin
      for (int k = 0; k < 12; k++) begin
        logic [NBR*W-1:0] rd;
        for (int j = 0; j < NBR*NSEC; j++) rd[j*SEC_W +: SEC_W] = 8'($urandom);
        apply(m[NSEC-2:0], (NBR*NSEC)'($urandom), rd, $urandom, "R8 sweep");
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule